// File: doc/BRIEF.md
# Bus Snoop Trigger Message Unit

This unit sits beside a processor's virtual bus and turns selected accesses into debug messages. It has two trigger sources. The first is a process-ID address: when software writes to that address, the written data is taken as the identity of the process now running, and an ownership message carries it out. An operating system writes to this address on every context switch, so a debug host can follow which task owns the processor. The second source is a set of four watchpoints. Each watchpoint compares the full access address against its own programmed address and qualifies the match by access direction: read, write or either. Any watchpoints that fire in one cycle are reported together in one watchpoint message as a bit mask. In the following cycle a one-cycle event pulse is driven on a pin that external equipment, such as a logic analyzer or a current probe, can use as a trigger.

Both kinds of message share a two-entry queue that drives a valid/ready message port. Each message carries a transfer code, the source processor number and a payload whose length depends on the transfer code. The queue occupancy is a three-state machine: EMPTY, ONE and FULL. Its transitions are EMPTY to ONE (one message accepted), EMPTY to FULL (two accepted together), ONE to EMPTY (pop, nothing accepted), ONE to ONE (pop and one accepted, or idle), ONE to FULL (one accepted, no pop) and FULL to ONE (pop). FULL stays FULL when there is no pop. The enable input is not cleared by reset, so messaging can be on before reset ends.

Top module: `snoop_trig_msg`

## Requirements
- R1: While reset is asserted and right after it, msg_valid, evt_out and overrun are 0.
- R2: An enabled bus write to pid_addr makes msg_valid 1 in the next cycle, with msg_tcode = 2, msg_payload = the written data and msg_plen = 32.
- R3: A read of pid_addr, a write to any other address, and a cycle with bus_valid = 0 produce no ownership message.
- R4: Watchpoint i uses address wp_addr[32*i+31:32*i] and mode wp_mode[2*i+1:2*i]. The modes are 00 = off, 01 = reads only, 10 = writes only and 11 = either direction. The whole address must match.
- R5: All watchpoints that hit in one cycle give one message in the next cycle, with msg_tcode = 15, msg_plen = 4 and bit i of msg_payload set for watchpoint i. The upper payload bits are 0.
- R6: evt_out is 1 for exactly the one cycle after each cycle with a watchpoint hit. This holds even when the message is dropped.
- R7: If an ownership trigger and a watchpoint hit happen in the same cycle, both messages are queued, the ownership message first.
- R8: The queue holds two messages. Free space is taken from the occupancy at the start of the cycle, so a pop in that cycle does not make room. Messages that do not fit are dropped and set overrun, which stays 1 until reset.
- R9: A message is removed when msg_valid and msg_ready are both 1. While msg_valid = 1 and msg_ready = 0, the message outputs hold their values.
- R10: With msg_en = 0, no message and no event are produced. If msg_en is held at 1 through reset, an access in the first cycle after reset is captured.
- R11: msg_src carries the src_id value that was present when the triggering access happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_en | input | 1 | Enables triggers, messages and events |
| src_id | input | 4 | Source processor number placed in messages |
| pid_addr | input | 32 | Process-ID address |
| wp_addr | input | 128 | Four watchpoint addresses, packed |
| wp_mode | input | 8 | Four 2-bit watchpoint modes, packed |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Access address |
| bus_wdata | input | 32 | Data bus value |
| evt_out | output | 1 | One-cycle watchpoint event pulse |
| msg_valid | output | 1 | Queue head valid |
| msg_ready | input | 1 | Consumer accepts the head |
| msg_tcode | output | 6 | Transfer code |
| msg_src | output | 4 | Source processor number |
| msg_plen | output | 6 | Payload length in bits |
| msg_payload | output | 32 | Payload |
| overrun | output | 1 | Sticky message-drop flag |

## Verification
A table drives single accesses that differ in only one respect from a trigger: a read of the process-ID address, a write to a neighbouring address, an idle cycle at the trigger address, and an address one above a watchpoint. The same watchpoint address is read and then written, which separates the read-only, write-only and either-direction qualifiers through the mask each access yields. Directed sequences then fill the queue with the consumer stalled to show dropping, the sticky flag and event pulses that continue while messages are lost. They also offer a new message to a full queue in the cycle it pops, which separates start-of-cycle space from freed space. A write that triggers both sources at once shows the ordering and the hold behaviour. A trigger asserted across the reset edge shows that messaging is live from the first cycle.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    localparam int TC_W = 6;
    localparam logic [TC_W-1:0] TC_OWN = 6'd2;
    localparam logic [TC_W-1:0] TC_WP  = 6'd15;

    typedef enum logic [1:0] {
        WPM_OFF = 2'b00,
        WPM_RD  = 2'b01,
        WPM_WR  = 2'b10,
        WPM_ANY = 2'b11
    } wp_mode_e;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_ONE   = 2'd1,
        Q_FULL  = 2'd2
    } q_state_e;

endpackage

// File: rtl/snoop_wp_match.sv
module snoop_wp_match
    import snoop_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          en,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [AW-1:0] cfg_addr,
    input  logic [1:0]    cfg_mode,
    output logic          hit
);

    logic dir_ok;

    always_comb begin
        unique case (wp_mode_e'(cfg_mode))
            WPM_OFF: dir_ok = 1'b0;
            WPM_RD:  dir_ok = ~bus_write;
            WPM_WR:  dir_ok = bus_write;
            WPM_ANY: dir_ok = 1'b1;
        endcase
    end

    assign hit = en && bus_valid && dir_ok && (bus_addr == cfg_addr);

endmodule

// File: rtl/snoop_msg_queue.sv
module snoop_msg_queue
    import snoop_pkg::*;
#(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_a_vld,
    input  logic [W-1:0] in_a,
    input  logic         in_b_vld,
    input  logic [W-1:0] in_b,
    input  logic         pop,
    output logic         head_vld,
    output logic [W-1:0] head,
    output logic         drop
);

    q_state_e     st, st_nx;
    logic [W-1:0] slot0, slot1, nx0, nx1, first;
    logic [1:0]   occ, space, n_push, acc, base, cnt_nx;
    logic         pop_eff;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= Q_EMPTY;
        else        st <= st_nx;
    end

    // occupancy, acceptance and next contents
    always_comb begin
        unique case (st)
            Q_EMPTY: occ = 2'd0;
            Q_ONE:   occ = 2'd1;
            Q_FULL:  occ = 2'd2;
            default: occ = 2'd0;
        endcase
        pop_eff = pop && (st != Q_EMPTY);
        n_push  = {1'b0, in_a_vld} + {1'b0, in_b_vld};
        space   = 2'd2 - occ;
        drop    = n_push > space;
        acc     = drop ? space : n_push;
        first   = in_a_vld ? in_a : in_b;
        base    = occ - {1'b0, pop_eff};
        nx0     = pop_eff ? slot1 : slot0;
        nx1     = slot1;
        if (acc != 2'd0) begin
            if (base == 2'd0) nx0 = first;
            else              nx1 = first;
        end
        if (acc == 2'd2) nx1 = in_b;
        cnt_nx = base + acc;
        unique case (cnt_nx)
            2'd0:    st_nx = Q_EMPTY;
            2'd1:    st_nx = Q_ONE;
            default: st_nx = Q_FULL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot0 <= '0;
            slot1 <= '0;
        end else begin
            slot0 <= nx0;
            slot1 <= nx1;
        end
    end

    assign head_vld = (st != Q_EMPTY);
    assign head     = slot0;

endmodule

// File: rtl/snoop_trig_msg.sv
module snoop_trig_msg
    import snoop_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int NUM_WP = 4,
    parameter int SRC_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     msg_en,
    input  logic [SRC_W-1:0]         src_id,
    input  logic [AW-1:0]            pid_addr,
    input  logic [NUM_WP*AW-1:0]     wp_addr,
    input  logic [NUM_WP*2-1:0]      wp_mode,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic                     evt_out,
    output logic                     msg_valid,
    input  logic                     msg_ready,
    output logic [TC_W-1:0]          msg_tcode,
    output logic [SRC_W-1:0]         msg_src,
    output logic [$clog2(DW+1)-1:0]  msg_plen,
    output logic [DW-1:0]            msg_payload,
    output logic                     overrun
);

    localparam int PLEN_W = $clog2(DW + 1);
    localparam int MSG_W  = TC_W + SRC_W + PLEN_W + DW;
    localparam logic [PLEN_W-1:0] OWN_LEN = PLEN_W'(DW);
    localparam logic [PLEN_W-1:0] WP_LEN  = PLEN_W'(NUM_WP);

    logic [NUM_WP-1:0] wp_hit;
    logic              own_hit, any_wp, drop;
    logic [MSG_W-1:0]  own_msg, wp_msg, head;

    for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
        snoop_wp_match #(.AW(AW)) u_wp (
            .en        (msg_en),
            .bus_valid (bus_valid),
            .bus_write (bus_write),
            .bus_addr  (bus_addr),
            .cfg_addr  (wp_addr[i*AW +: AW]),
            .cfg_mode  (wp_mode[2*i +: 2]),
            .hit       (wp_hit[i])
        );
    end

    assign own_hit = msg_en && bus_valid && bus_write && (bus_addr == pid_addr);
    assign any_wp  = |wp_hit;
    assign own_msg = {TC_OWN, src_id, OWN_LEN, bus_wdata};
    assign wp_msg  = {TC_WP, src_id, WP_LEN, DW'(wp_hit)};

    snoop_msg_queue #(.W(MSG_W)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_a_vld (own_hit),
        .in_a     (own_msg),
        .in_b_vld (any_wp),
        .in_b     (wp_msg),
        .pop      (msg_ready),
        .head_vld (msg_valid),
        .head     (head),
        .drop     (drop)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_out <= 1'b0;
            overrun <= 1'b0;
        end else begin
            evt_out <= any_wp;
            overrun <= overrun | drop;
        end
    end

    assign {msg_tcode, msg_src, msg_plen, msg_payload} = head;

endmodule

// File: rtl/snoop_trig_msg_chk.sv
module snoop_trig_msg_chk
    import snoop_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int NUM_WP = 4,
    parameter int SRC_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    msg_en,
    input logic [AW-1:0]           pid_addr,
    input logic                    bus_valid,
    input logic                    bus_write,
    input logic [AW-1:0]           bus_addr,
    input logic [DW-1:0]           bus_wdata,
    input logic                    evt_out,
    input logic                    msg_valid,
    input logic                    msg_ready,
    input logic [TC_W-1:0]         msg_tcode,
    input logic [$clog2(DW+1)-1:0] msg_plen,
    input logic [DW-1:0]           msg_payload,
    input logic                    overrun
);

    p_own_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_en && bus_valid && bus_write && bus_addr == pid_addr && !msg_valid)
        |=> (msg_valid && msg_tcode == TC_OWN && msg_payload == $past(bus_wdata)));

    p_code_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ((msg_tcode == TC_OWN && int'(msg_plen) == DW) ||
                       (msg_tcode == TC_WP && int'(msg_plen) == NUM_WP &&
                        msg_payload[NUM_WP-1:0] != '0 &&
                        (msg_payload >> NUM_WP) == '0)));

    p_no_evt_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(msg_en && bus_valid) |=> !evt_out);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=>
        (msg_valid && $stable(msg_payload) && $stable(msg_tcode) && $stable(msg_plen)));

    p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_en && !msg_valid) |=> !msg_valid);

endmodule

bind snoop_trig_msg snoop_trig_msg_chk #(
    .AW(AW), .DW(DW), .NUM_WP(NUM_WP), .SRC_W(SRC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_en      (msg_en),
    .pid_addr    (pid_addr),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .evt_out     (evt_out),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg_tcode   (msg_tcode),
    .msg_plen    (msg_plen),
    .msg_payload (msg_payload),
    .overrun     (overrun)
);

// File: tb/tb_snoop_trig_msg.sv
module tb_snoop_trig_msg;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n, msg_en, bus_valid, bus_write, msg_ready;
    logic [3:0]   src_id;
    logic [31:0]  pid_addr, bus_addr, bus_wdata;
    logic [127:0] wp_addr;
    logic [7:0]   wp_mode;
    logic         evt_out, msg_valid, overrun;
    logic [5:0]   msg_tcode, msg_plen;
    logic [3:0]   msg_src;
    logic [31:0]  msg_payload;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_trig_msg dut (
        .clk(clk), .rst_n(rst_n), .msg_en(msg_en), .src_id(src_id),
        .pid_addr(pid_addr), .wp_addr(wp_addr), .wp_mode(wp_mode),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .evt_out(evt_out), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_tcode(msg_tcode), .msg_src(msg_src),
        .msg_plen(msg_plen), .msg_payload(msg_payload), .overrun(overrun)
    );

    typedef struct packed {
        logic        v;
        logic        w;
        logic [31:0] addr;
        logic [31:0] data;
        logic        ev;
        logic [5:0]  tc;
        logic [31:0] pay;
        logic        evt;
    } vec_t;

    localparam vec_t TBL [0:9] = '{
        '{1'b1, 1'b1, 32'h1000, 32'hCAFE0001, 1'b1, 6'd2,  32'hCAFE0001, 1'b0},
        '{1'b1, 1'b0, 32'h1000, 32'h11111111, 1'b0, 6'd0,  32'h0,        1'b0},
        '{1'b1, 1'b1, 32'h1004, 32'h22222222, 1'b0, 6'd0,  32'h0,        1'b0},
        '{1'b1, 1'b0, 32'h2000, 32'h0,        1'b1, 6'd15, 32'h9,        1'b1},
        '{1'b1, 1'b1, 32'h2000, 32'h0,        1'b1, 6'd15, 32'hA,        1'b1},
        '{1'b1, 1'b0, 32'h3000, 32'h0,        1'b1, 6'd15, 32'h4,        1'b1},
        '{1'b1, 1'b1, 32'h3000, 32'h0,        1'b1, 6'd15, 32'h4,        1'b1},
        '{1'b0, 1'b1, 32'h1000, 32'h33333333, 1'b0, 6'd0,  32'h0,        1'b0},
        '{1'b1, 1'b0, 32'h2001, 32'h0,        1'b0, 6'd0,  32'h0,        1'b0},
        '{1'b1, 1'b1, 32'h1000, 32'h00000007, 1'b1, 6'd2,  32'h00000007, 1'b0}
    };

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w,
                         input logic [31:0] a, input logic [31:0] d);
        bus_valid = v;
        bus_write = w;
        bus_addr  = a;
        bus_wdata = d;
    endtask

    initial begin
        rst_n = 1'b0; msg_en = 1'b1; msg_ready = 1'b1; src_id = 4'd5;
        pid_addr = 32'h1000;
        wp_addr  = {32'h2000, 32'h3000, 32'h2000, 32'h2000};
        wp_mode  = {2'b11, 2'b11, 2'b10, 2'b01};
        drive(1'b0, 1'b0, 32'h0, 32'h0);
        repeat (3) @(negedge clk);
        chk(!msg_valid && !evt_out && !overrun, "R1 reset outputs",
            {msg_valid, evt_out, overrun}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!msg_valid && !evt_out && !overrun, "R1 after reset",
            {msg_valid, evt_out, overrun}, 0);

        // vector table, consumer always ready
        for (int k = 0; k < 10; k++) begin
            string tag;
            drive(TBL[k].v, TBL[k].w, TBL[k].addr, TBL[k].data);
            @(negedge clk);
            tag = TBL[k].ev ? ((TBL[k].tc == 6'd2) ? "R2" : "R5") : "R3";
            chk(msg_valid == TBL[k].ev, $sformatf("%s vec %0d valid", tag, k),
                msg_valid, TBL[k].ev);
            if (TBL[k].ev) begin
                chk(msg_tcode == TBL[k].tc && msg_payload == TBL[k].pay,
                    $sformatf("%s vec %0d tcode/payload", tag, k),
                    {msg_tcode, msg_payload}, {TBL[k].tc, TBL[k].pay});
                chk(msg_plen == ((TBL[k].tc == 6'd2) ? 6'd32 : 6'd4),
                    $sformatf("%s vec %0d plen", tag, k), msg_plen,
                    (TBL[k].tc == 6'd2) ? 32 : 4);
                chk(msg_src == 4'd5, "R11 source id", msg_src, 5);
            end
            chk(evt_out == TBL[k].evt, $sformatf("R6 vec %0d event", k),
                evt_out, TBL[k].evt);
        end
        drive(1'b0, 1'b0, 32'h0, 32'h0);
        @(negedge clk);
        chk(!msg_valid, "R9 drained", msg_valid, 0);

        // disabled
        msg_en = 1'b0;
        drive(1'b1, 1'b1, 32'h1000, 32'hDEAD);
        @(negedge clk);
        chk(!msg_valid && !evt_out, "R10 disabled own", {msg_valid, evt_out}, 0);
        drive(1'b1, 1'b0, 32'h2000, 32'h0);
        @(negedge clk);
        chk(!msg_valid && !evt_out, "R10 disabled wp", {msg_valid, evt_out}, 0);
        msg_en = 1'b1;
        drive(1'b0, 1'b0, 32'h0, 32'h0);
        @(negedge clk);

        // overflow with stalled consumer
        msg_ready = 1'b0;
        drive(1'b1, 1'b0, 32'h2000, 32'h0);
        @(negedge clk);
        chk(msg_valid && evt_out && !overrun, "R8 first fill",
            {msg_valid, evt_out, overrun}, 3'b110);
        @(negedge clk);
        chk(evt_out && !overrun, "R8 second fill", {evt_out, overrun}, 2'b10);
        @(negedge clk);
        chk(overrun, "R8 overrun set", overrun, 1);
        chk(evt_out, "R6 event on dropped hit", evt_out, 1);
        drive(1'b0, 1'b0, 32'h0, 32'h0);
        @(negedge clk);
        chk(!evt_out, "R6 single-cycle pulse", evt_out, 0);
        msg_ready = 1'b1;
        @(negedge clk);
        chk(msg_valid && msg_payload == 32'h9, "R9 second entry",
            {msg_valid, msg_payload}, {1'b1, 32'h9});
        @(negedge clk);
        chk(!msg_valid && overrun, "R8 empty, flag sticky",
            {msg_valid, overrun}, 2'b01);

        // full queue offered a message in its pop cycle
        msg_ready = 1'b0;
        drive(1'b1, 1'b0, 32'h2000, 32'h0);
        @(negedge clk);
        drive(1'b1, 1'b1, 32'h2000, 32'h0);
        @(negedge clk);
        chk(msg_payload == 32'h9, "R9 head held", msg_payload, 32'h9);
        msg_ready = 1'b1;
        drive(1'b1, 1'b0, 32'h3000, 32'h0);
        @(negedge clk);
        chk(msg_valid && msg_payload == 32'hA, "R8 head after pop",
            {msg_valid, msg_payload}, {1'b1, 32'hA});
        drive(1'b0, 1'b0, 32'h0, 32'h0);
        @(negedge clk);
        chk(!msg_valid, "R8 message offered to full queue dropped", msg_valid, 0);

        // ownership and watchpoint in the same cycle
        wp_addr[64 +: 32] = 32'h1000;
        wp_mode[5:4]      = 2'b10;
        msg_ready = 1'b0;
        drive(1'b1, 1'b1, 32'h1000, 32'h12345678);
        @(negedge clk);
        chk(msg_valid && msg_tcode == 6'd2 && msg_payload == 32'h12345678,
            "R7 ownership first", {msg_tcode, msg_payload}, {6'd2, 32'h12345678});
        chk(evt_out, "R6 event with ownership", evt_out, 1);
        drive(1'b0, 1'b0, 32'h0, 32'h0);
        @(negedge clk);
        chk(msg_valid && msg_tcode == 6'd2 && msg_payload == 32'h12345678,
            "R9 stall hold", {msg_tcode, msg_payload}, {6'd2, 32'h12345678});
        msg_ready = 1'b1;
        @(negedge clk);
        chk(msg_valid && msg_tcode == 6'd15 && msg_payload == 32'h4 && msg_plen == 6'd4,
            "R7 watchpoint second", {msg_tcode, msg_payload}, {6'd15, 32'h4});
        @(negedge clk);
        chk(!msg_valid, "R7 both consumed", msg_valid, 0);

        // watchpoint switched off
        wp_addr[64 +: 32] = 32'h3000;
        wp_mode[5:4]      = 2'b00;
        drive(1'b1, 1'b0, 32'h3000, 32'h0);
        @(negedge clk);
        chk(!msg_valid && !evt_out, "R4 mode off", {msg_valid, evt_out}, 0);
        drive(1'b1, 1'b1, 32'h3000, 32'h0);
        @(negedge clk);
        chk(!msg_valid && !evt_out, "R4 mode off write", {msg_valid, evt_out}, 0);

        // enabled across reset
        rst_n = 1'b0;
        drive(1'b1, 1'b1, 32'h1000, 32'h55);
        @(negedge clk);
        @(negedge clk);
        chk(!overrun && !msg_valid, "R8 reset clears flag", {overrun, msg_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(msg_valid && msg_payload == 32'h55, "R10 first cycle after reset",
            {msg_valid, msg_payload}, {1'b1, 32'h55});
        drive(1'b0, 1'b0, 32'h0, 32'h0);
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule